// File: doc/BRIEF.md
# Shared SRAM Controller with Host Takeover

This block places one asynchronous static RAM of 16-bit words behind two requesters. A processor reaches it through a Wishbone slave port. A maintenance host reaches it through a small command port that can load programs and read them back. By default the processor owns the memory. The host can claim ownership with a select command and hand it back with a release command. While the host owns the memory, processor requests wait with no acknowledge.

Each SRAM access takes two system cycles. Address, byte enables and write data are held for both cycles. The active-low write strobe comes from a clock running at twice the system rate. It falls in the middle of the first cycle and rises in the middle of the second, which leaves half a system cycle of setup and half a cycle of hold around the strobe. A 32-bit processor access is made of two such accesses, the low half-word first.

The block also watches processor writes to one reserved byte address. The low bits of that write are kept in a completion register. This register drives a display output, and the host can read it at any time, whoever owns the memory. Software writes a non-zero value there when a program ends.

Top module: `sram_share_ctrl`

## Requirements
- R1: After reset the SRAM is idle (chip enable, output enable and write enable high, byte enables both high, data not driven). No acknowledge or done is raised, the processor owns the memory and the completion register reads zero.
- R2: A processor write accepted at a rising clock edge while idle is made as two SRAM accesses, to word addresses {adr[AW:2],0} and then {adr[AW:2],1}. The low data half goes to the first word. The acknowledge is seen after the 5th rising edge, counting the accepting edge as the first, and lasts one cycle.
- R3: For each half-word access, write byte enable bit 0 (data bits 7:0) is low when select bit 0 is set (low half) or bit 2 is set (high half). Bit 1 (data bits 15:8) follows select bit 1 or bit 3. Bytes that are not selected keep their old contents.
- R4: A processor read returns {second word, first word} on the data output in the acknowledge cycle, with the same timing as R2.
- R5: During an SRAM write access, write enable is low for exactly one system clock period. It falls mid-way through the first access cycle and rises mid-way through the second.
- R6: Write enable is never low unless chip enable is low, output enable is high and the data bus is driven. Output enable is low only during read accesses.
- R7: Host command 0 (select) gives the memory to the host, and command 1 (release) returns it to the processor. The ownership output shows which one holds it. While the host owns the memory, processor requests get no acknowledge and cause no SRAM access.
- R8: With the host owning the memory, command 2 (write) stores the 16-bit data with both byte enables low, and command 3 (read) returns the 16-bit word. Each signals done after the 3rd rising edge, counting the accepting edge as the first.
- R9: A host read or write issued while the processor owns the memory makes no SRAM access. It signals done after the first rising edge, and a read returns zero.
- R10: A processor write whose byte address equals STATUS_ADDR (0xFFFC by default) loads data bits STAT_W-1:0 into the completion register at the acknowledge. No other write changes that register, including a host write to the same memory word.
- R11: Host command 4 returns the completion register zero-extended to 16 bits, whichever requester owns the memory. Done is signalled after the first rising edge.
- R12: A processor read of STATUS_ADDR leaves the completion register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clk2x | input | 1 | Clock at twice the system rate, rising edges aligned with clk |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Wishbone cycle |
| wb_stb_i | input | 1 | Wishbone strobe from the address decoder |
| wb_we_i | input | 1 | Wishbone write |
| wb_adr_i | input | AW+1 | Processor byte address |
| wb_dat_i | input | 32 | Processor write data |
| wb_sel_i | input | 4 | Processor byte selects |
| wb_dat_o | output | 32 | Processor read data |
| wb_ack_o | output | 1 | Wishbone acknowledge |
| host_valid_i | input | 1 | Host command valid, held until done |
| host_op_i | input | 3 | Host command: 0 select, 1 release, 2 write, 3 read, 4 completion read |
| host_addr_i | input | AW | Host word address |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data |
| host_done_o | output | 1 | One-cycle completion of a host command |
| host_owns_o | output | 1 | High while the host owns the SRAM |
| sram_addr_o | output | AW | SRAM word address |
| sram_dq_i | input | 16 | SRAM read data |
| sram_dq_o | output | 16 | SRAM write data |
| sram_dq_oe_o | output | 1 | Drive enable for the SRAM data bus |
| sram_ce_n_o | output | 1 | SRAM chip enable, active low |
| sram_oe_n_o | output | 1 | SRAM output enable, active low |
| sram_we_n_o | output | 1 | SRAM write enable, active low |
| sram_be_n_o | output | 2 | SRAM byte enables, active low (bit 1 = upper byte) |
| status_o | output | STAT_W | Completion register for the display |

## Verification
The bench builds the block with its defaults: an 18-bit word address, an 8-bit completion register and the reserved address 0xFFFC. The narrow register makes the zero-extension of host reads visible. The full address width lets the reserved word at the top of the 64 KB region sit next to ordinary words. Sampling on the falling edge of the double-rate clock measures the strobe width and its placement. The completion register is compared with a model on every cycle, so a stray load shows up in the cycle where it happens.

// File: rtl/sram_share_pkg.sv
package sram_share_pkg;

  typedef enum logic [2:0] {
    HOP_SELECT  = 3'd0,
    HOP_RELEASE = 3'd1,
    HOP_WRITE   = 3'd2,
    HOP_READ    = 3'd3,
    HOP_STATUS  = 3'd4
  } host_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_HOLD  = 2'd2,
    ST_DONE  = 2'd3
  } xfer_st_e;

  // active-low byte enables for one half-word of a 32-bit access
  function automatic logic [1:0] lane_be_n(input logic [3:0] sel, input logic upper);
    return upper ? ~sel[3:2] : ~sel[1:0];
  endfunction

  // pick the half-word of a 32-bit value that a given access carries
  function automatic logic [15:0] lane_data(input logic [31:0] d, input logic upper);
    return upper ? d[31:16] : d[15:0];
  endfunction

endpackage

// File: rtl/sram_we_strobe.sv
module sram_we_strobe (
  input  logic clk2x,
  input  logic rst_n,
  input  logic arm_i,
  output logic we_n_o
);
  logic we_n_q;

  // arm_i is high for one system cycle, i.e. two double-rate edges;
  // the first of them lies mid-cycle, so the strobe spans mid-to-mid
  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) we_n_q <= 1'b1;
    else        we_n_q <= ~arm_i;
  end

  assign we_n_o = we_n_q;

  // R5: strobe lasts exactly two double-rate periods
  a_r5_strobe_width: assert property (@(posedge clk2x) disable iff (!rst_n)
    $fell(we_n_q) |=> (!we_n_q ##1 we_n_q));
endmodule

// File: rtl/sram_status_latch.sv
module sram_status_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (load_i) q <= data_i;
  end

  assign q_o = q;

  // R10: the register only moves after a qualifying processor write
  a_r10_change_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |-> $past(load_i));
endmodule

// File: rtl/sram_share_ctrl.sv
module sram_share_ctrl
  import sram_share_pkg::*;
#(
  parameter int AW = 18,
  parameter int STAT_W = 8,
  parameter logic [AW:0] STATUS_ADDR = (AW+1)'(32'hFFFC)
) (
  input  logic              clk,
  input  logic              clk2x,
  input  logic              rst_n,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [AW:0]       wb_adr_i,
  input  logic [31:0]       wb_dat_i,
  input  logic [3:0]        wb_sel_i,
  output logic [31:0]       wb_dat_o,
  output logic              wb_ack_o,
  input  logic              host_valid_i,
  input  logic [2:0]        host_op_i,
  input  logic [AW-1:0]     host_addr_i,
  input  logic [15:0]       host_wdata_i,
  output logic [15:0]       host_rdata_o,
  output logic              host_done_o,
  output logic              host_owns_o,
  output logic [AW-1:0]     sram_addr_o,
  input  logic [15:0]       sram_dq_i,
  output logic [15:0]       sram_dq_o,
  output logic              sram_dq_oe_o,
  output logic              sram_ce_n_o,
  output logic              sram_oe_n_o,
  output logic              sram_we_n_o,
  output logic [1:0]        sram_be_n_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int HALF_W = 16;
  localparam logic [3:0] HOST_SEL = 4'b0011;

  xfer_st_e       st_q;
  host_op_e       op_q;
  logic           is_host_q, is_wr_q, hi_q, own_q;
  logic [AW-1:0]  haddr_q;
  logic [AW:0]    badr_q;
  logic [31:0]    wdata_q, rdbuf_q;
  logic [3:0]     sel_q;
  logic [HALF_W-1:0] hrdata_q;

  // named internal events
  logic access_w, wr_first_w, cpu_commit_w, status_hit_w;
  logic [STAT_W-1:0] status_w;
  logic [HALF_W-1:0] status_wide_w;
  host_op_e       op_in_w;

  assign op_in_w = host_op_e'(host_op_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; op_q <= HOP_SELECT;
      is_host_q <= 1'b0; is_wr_q <= 1'b0; hi_q <= 1'b0; own_q <= 1'b0;
      haddr_q <= '0; badr_q <= '0; wdata_q <= '0; rdbuf_q <= '0;
      sel_q <= '0; hrdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          hi_q <= 1'b0;
          if (host_valid_i) begin
            is_host_q <= 1'b1;
            op_q      <= op_in_w;
            haddr_q   <= host_addr_i;
            wdata_q   <= {16'h0000, host_wdata_i};
            sel_q     <= HOST_SEL;
            is_wr_q   <= (op_in_w == HOP_WRITE);
            hrdata_q  <= (op_in_w == HOP_STATUS) ? status_wide_w : '0;
            if ((op_in_w == HOP_WRITE || op_in_w == HOP_READ) && own_q) st_q <= ST_SETUP;
            else                                                          st_q <= ST_DONE;
          end else if (wb_cyc_i && wb_stb_i && !own_q) begin
            is_host_q <= 1'b0;
            badr_q    <= wb_adr_i;
            wdata_q   <= wb_dat_i;
            sel_q     <= wb_sel_i;
            is_wr_q   <= wb_we_i;
            st_q      <= ST_SETUP;
          end
        end
        ST_SETUP: st_q <= ST_HOLD;
        ST_HOLD: begin
          if (!is_wr_q) begin
            if (is_host_q)  hrdata_q <= sram_dq_i;
            else if (hi_q)  rdbuf_q[31:16] <= sram_dq_i;
            else            rdbuf_q[15:0]  <= sram_dq_i;
          end
          if (!is_host_q && !hi_q) begin
            hi_q <= 1'b1;
            st_q <= ST_SETUP;
          end else begin
            st_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (is_host_q && op_q == HOP_SELECT)  own_q <= 1'b1;
          if (is_host_q && op_q == HOP_RELEASE) own_q <= 1'b0;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // SRAM pins follow the registered access state
  assign access_w     = (st_q == ST_SETUP) || (st_q == ST_HOLD);
  assign wr_first_w   = (st_q == ST_SETUP) && is_wr_q;
  assign sram_ce_n_o  = ~access_w;
  assign sram_oe_n_o  = ~(access_w && !is_wr_q);
  assign sram_dq_oe_o = access_w && is_wr_q;
  assign sram_be_n_o  = access_w ? lane_be_n(sel_q, hi_q) : 2'b11;
  assign sram_dq_o    = lane_data(wdata_q, hi_q);
  assign sram_addr_o  = is_host_q ? haddr_q : {badr_q[AW:2], hi_q};

  assign wb_ack_o     = (st_q == ST_DONE) && !is_host_q;
  assign wb_dat_o     = rdbuf_q;
  assign host_done_o  = (st_q == ST_DONE) && is_host_q;
  assign host_rdata_o = hrdata_q;
  assign host_owns_o  = own_q;

  assign status_hit_w = (badr_q == STATUS_ADDR);
  assign cpu_commit_w = wb_ack_o && is_wr_q && status_hit_w;

  always_comb begin
    status_wide_w = '0;
    status_wide_w[STAT_W-1:0] = status_w;
  end

  sram_we_strobe u_we (
    .clk2x (clk2x),
    .rst_n (rst_n),
    .arm_i (wr_first_w),
    .we_n_o(sram_we_n_o)
  );

  sram_status_latch #(.W(STAT_W)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(cpu_commit_w),
    .data_i(wdata_q[STAT_W-1:0]),
    .q_o   (status_w)
  );

  assign status_o = status_w;

  // R2: acknowledge is a single-cycle pulse
  a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack_o |=> !wb_ack_o);
  // R7: no processor acknowledge while the host owns the memory
  a_r7_cpu_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    host_owns_o |-> !wb_ack_o);
  // R8: host done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    host_done_o |=> !host_done_o);
  // R6: write strobe only inside a driven, selected, non-reading access
  a_r6_we_in_write: assert property (@(posedge clk2x) disable iff (!rst_n)
    !sram_we_n_o |-> (!sram_ce_n_o && sram_oe_n_o && sram_dq_oe_o));
endmodule

// File: tb/sram_share_ctrl_tb.sv
`timescale 1ns/1ps
module sram_share_ctrl_tb;
  localparam int AW = 18;
  localparam int SW = 8;

  logic clk = 1'b0, clk2x = 1'b0, rst_n = 1'b0;
  logic wb_cyc = 0, wb_stb = 0, wb_we = 0;
  logic [AW:0] wb_adr = '0;
  logic [31:0] wb_dat_i = '0, wb_dat_o;
  logic [3:0] wb_sel = '0;
  logic wb_ack;
  logic host_valid = 0;
  logic [2:0] host_op = '0;
  logic [AW-1:0] host_addr = '0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic host_done, host_owns;
  logic [AW-1:0] sram_addr;
  logic [15:0] sram_dq_i, sram_dq_o;
  logic sram_dq_oe, sram_ce_n, sram_oe_n, sram_we_n;
  logic [1:0] sram_be_n;
  logic [SW-1:0] status;

  int errors = 0, checks = 0;
  logic [15:0] mem [0:(1<<AW)-1];
  logic [SW-1:0] exp_status = '0;
  bit run_cmp = 0;
  bit expect_idle = 0;
  int we_low_cnt = 0;
  int cyc_cnt = 0;

  always #1.25 clk2x = ~clk2x;
  always @(posedge clk2x) clk <= ~clk;

  sram_share_ctrl u_dut (
    .clk(clk), .clk2x(clk2x), .rst_n(rst_n),
    .wb_cyc_i(wb_cyc), .wb_stb_i(wb_stb), .wb_we_i(wb_we), .wb_adr_i(wb_adr),
    .wb_dat_i(wb_dat_i), .wb_sel_i(wb_sel), .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack),
    .host_valid_i(host_valid), .host_op_i(host_op), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata), .host_done_o(host_done),
    .host_owns_o(host_owns), .sram_addr_o(sram_addr), .sram_dq_i(sram_dq_i),
    .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe), .sram_ce_n_o(sram_ce_n),
    .sram_oe_n_o(sram_oe_n), .sram_we_n_o(sram_we_n), .sram_be_n_o(sram_be_n),
    .status_o(status)
  );

  // behavioural asynchronous SRAM
  assign sram_dq_i = (!sram_ce_n && !sram_oe_n) ?
    {sram_be_n[1] ? 8'h00 : mem[sram_addr][15:8], sram_be_n[0] ? 8'h00 : mem[sram_addr][7:0]} : 16'h0000;
  always @(posedge sram_we_n) begin
    if (rst_n && !sram_ce_n) begin
      if (!sram_be_n[0]) mem[sram_addr][7:0]  = sram_dq_o[7:0];
      if (!sram_be_n[1]) mem[sram_addr][15:8] = sram_dq_o[15:8];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R6/R5: strobe qualification and width, sampled off the double-rate edge
  always @(negedge clk2x) begin
    if (rst_n && !sram_we_n) begin
      we_low_cnt++;
      if (sram_ce_n || !sram_oe_n || !sram_dq_oe) begin
        errors++; checks++;
        $display("FAIL R6: actual=%b%b%b expected=010", sram_ce_n, sram_oe_n, sram_dq_oe);
      end
    end
  end

  // per-cycle reference comparison: completion register (R10) and idle bus (R7)
  always @(posedge clk) begin
    #1;
    if (run_cmp) begin
      if (status !== exp_status) chk(0, "R10 status", 32'(status), 32'(exp_status));
      if (expect_idle && !sram_ce_n) chk(0, "R7 idle bus", 32'(sram_ce_n), 32'd1);
    end
  end

  task automatic cpu_xfer(input logic [AW:0] adr, input bit we, input logic [31:0] d,
                          input logic [3:0] sel, output logic [31:0] rd, output int n);
    @(negedge clk);
    wb_adr = adr; wb_we = we; wb_dat_i = d; wb_sel = sel; wb_cyc = 1; wb_stb = 1;
    n = 0; rd = '0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); n++;
      if (wb_ack) begin rd = wb_dat_o; break; end
    end
    if (we && wb_ack && adr == 19'h0FFFC) exp_status = d[SW-1:0];
    wb_cyc = 0; wb_stb = 0;
  endtask

  task automatic host_cmd(input logic [2:0] op, input logic [AW-1:0] a, input logic [15:0] d,
                          output logic [15:0] rd, output int n);
    @(negedge clk);
    host_op = op; host_addr = a; host_wdata = d; host_valid = 1;
    n = 0; rd = '0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); n++;
      if (host_done) begin rd = host_rdata; break; end
    end
    host_valid = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      chk(0, "watchdog", 32'(cyc_cnt), 32'd100000);
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd32;
    logic [15:0] rd16;
    int n;
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(sram_ce_n && sram_oe_n && sram_we_n && sram_be_n == 2'b11 && !sram_dq_oe, "R1 bus idle",
        {27'd0, sram_ce_n, sram_oe_n, sram_we_n, sram_be_n}, 32'h1F);
    chk(!wb_ack && !host_done && !host_owns && status == 0, "R1 outputs",
        {28'd0, wb_ack, host_done, host_owns, |status}, 32'h0);
    run_cmp = 1;

    // R2/R5: full write
    we_low_cnt = 0;
    cpu_xfer(19'h00100, 1, 32'hA1B2C3D4, 4'hF, rd32, n);
    chk(n == 5, "R2 ack latency", 32'(n), 32'd5);
    chk(mem[18'h00080] == 16'hC3D4 && mem[18'h00081] == 16'hA1B2, "R2 half order",
        {mem[18'h00081], mem[18'h00080]}, 32'hA1B2C3D4);
    chk(we_low_cnt == 4, "R5 strobe width", 32'(we_low_cnt), 32'd4);

    // R4: read back
    cpu_xfer(19'h00100, 0, 32'h0, 4'hF, rd32, n);
    chk(rd32 == 32'hA1B2C3D4, "R4 read data", rd32, 32'hA1B2C3D4);
    chk(n == 5, "R4 read latency", 32'(n), 32'd5);

    // R3: partial selects
    cpu_xfer(19'h00200, 1, 32'hFFFFFFFF, 4'hF, rd32, n);
    cpu_xfer(19'h00200, 1, 32'h11223344, 4'b0110, rd32, n);
    cpu_xfer(19'h00200, 0, 32'h0, 4'hF, rd32, n);
    chk(rd32 == 32'hFF2233FF, "R3 byte lanes", rd32, 32'hFF2233FF);

    // R4/R2 several patterns
    for (int k = 0; k < 4; k++) begin
      logic [31:0] v;
      v = 32'h13579BDF ^ (32'h01010101 * k) ^ (k << 20);
      cpu_xfer(19'(32'h400 + k * 8), 1, v, 4'hF, rd32, n);
      cpu_xfer(19'(32'h400 + k * 8), 0, 32'h0, 4'hF, rd32, n);
      chk(rd32 == v, "R4 pattern", rd32, v);
    end

    // R11: completion register starts at zero
    host_cmd(3'd4, '0, '0, rd16, n);
    chk(rd16 == 16'h0000 && n == 1, "R11 status zero", {rd16, 16'(n)}, 32'h00000001);

    // R10: reserved address write
    cpu_xfer(19'h0FFFC, 1, 32'h000001A5, 4'hF, rd32, n);
    @(negedge clk);
    chk(status == 8'hA5, "R10 status load", 32'(status), 32'hA5);
    chk(mem[18'h07FFE] == 16'h01A5, "R10 memory also written", 32'(mem[18'h07FFE]), 32'h01A5);
    host_cmd(3'd4, '0, '0, rd16, n);
    chk(rd16 == 16'h00A5, "R11 zero-extend", 32'(rd16), 32'h00A5);

    // R10: neighbouring address; R12: read of reserved address
    cpu_xfer(19'h0FFF8, 1, 32'h00000077, 4'hF, rd32, n);
    cpu_xfer(19'h0FFFC, 0, 32'h0, 4'hF, rd32, n);
    @(negedge clk);
    chk(status == 8'hA5, "R12 read keeps status", 32'(status), 32'hA5);
    chk(rd32 == 32'h000001A5, "R12 read data", rd32, 32'h000001A5);

    // R9: host memory ops without ownership
    host_cmd(3'd2, 18'h00080, 16'hDEAD, rd16, n);
    chk(n == 1, "R9 write ignored latency", 32'(n), 32'd1);
    host_cmd(3'd3, 18'h00080, 16'h0, rd16, n);
    chk(rd16 == 16'h0 && n == 1, "R9 read zero", {rd16, 16'(n)}, 32'h00000001);
    chk(mem[18'h00080] == 16'hC3D4, "R9 memory untouched", 32'(mem[18'h00080]), 32'hC3D4);

    // R7: select, processor held off
    host_cmd(3'd0, '0, '0, rd16, n);
    @(negedge clk);
    chk(host_owns == 1'b1, "R7 select", 32'(host_owns), 32'd1);
    begin
      int acks = 0;
      @(negedge clk);
      expect_idle = 1;
      wb_adr = 19'h00100; wb_we = 1; wb_dat_i = 32'h0BADF00D; wb_sel = 4'hF; wb_cyc = 1; wb_stb = 1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (wb_ack) acks++;
      end
      wb_cyc = 0; wb_stb = 0;
      @(negedge clk);
      expect_idle = 0;
      chk(acks == 0, "R7 no ack while host owns", 32'(acks), 32'd0);
      chk(mem[18'h00080] == 16'hC3D4, "R7 no processor write", 32'(mem[18'h00080]), 32'hC3D4);
    end

    // R8: host write and read
    we_low_cnt = 0;
    host_cmd(3'd2, 18'h00080, 16'hBEEF, rd16, n);
    chk(n == 3, "R8 write latency", 32'(n), 32'd3);
    chk(we_low_cnt == 2, "R5 host strobe width", 32'(we_low_cnt), 32'd2);
    host_cmd(3'd3, 18'h00080, 16'h0, rd16, n);
    chk(rd16 == 16'hBEEF && n == 3, "R8 read back", {rd16, 16'(n)}, 32'hBEEF0003);
    host_cmd(3'd3, 18'h00081, 16'h0, rd16, n);
    chk(rd16 == 16'hA1B2, "R8 read other word", 32'(rd16), 32'hA1B2);

    // R10: host write of the reserved word leaves the register alone
    host_cmd(3'd2, 18'h07FFE, 16'h0042, rd16, n);
    @(negedge clk);
    chk(status == 8'hA5, "R10 host write ignored", 32'(status), 32'hA5);
    host_cmd(3'd4, '0, '0, rd16, n);
    chk(rd16 == 16'h00A5, "R11 read while host owns", 32'(rd16), 32'h00A5);

    // R7: release, processor sees host data
    host_cmd(3'd1, '0, '0, rd16, n);
    @(negedge clk);
    chk(host_owns == 1'b0, "R7 release", 32'(host_owns), 32'd0);
    cpu_xfer(19'h00100, 0, 32'h0, 4'hF, rd32, n);
    chk(rd32 == 32'hA1B2BEEF && n == 5, "R7 processor access restored", rd32, 32'hA1B2BEEF);

    // R10: status overwrite with a new value
    cpu_xfer(19'h0FFFC, 1, 32'h12345600, 4'hF, rd32, n);
    @(negedge clk);
    chk(status == 8'h00, "R10 status reload", 32'(status), 32'h00);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule